// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block turns one serial bit stream into 4-bit parallel words, running from a single bit-rate clock. One of two serial inputs is picked by a select pin, so the second input can serve as a loopback path during test. The picked stream is also sent back out through a one-clock register. From the bit clock, a divider chain makes a word-rate clock (divide by 4) and a double-word clock (divide by 8).

A rate input chooses when the parallel register loads. In the default rate it loads once every four bit clocks. In the alternate rate it loads once every eight bit clocks, holding the latest four bits. Two instances can then share the work of an 8-bit word, with the double-word clock keeping their load boundaries aligned.

An asynchronous slip input moves the word boundary by one bit for each pulse, because the divider skips one count. An active-low asynchronous reset clears the divider, the shift and word registers, and the echo register.

Top module: `sp_deser`

## Requirements
- R1: While rst_ni is low, q_o, clk_word_o, clk_pair_o and sout_o are 0. Taking rst_ni low forces them to 0 at once, with no clock edge needed.
- R2: sout_o takes, at each rising edge, the input picked by sel_i (0 picks sin_a_i, 1 picks sin_b_i). The value is visible one clock after it was present on that input.
- R3: The bit shifted in at the earliest edge of a word appears on q_o[0], and later bits follow in order up to q_o[3].
- R4: With mode_i = 0, q_o loads at rising edges 4, 8, 12, and so on after reset release, each time with the last four bits. It holds its value between those edges.
- R5: With mode_i = 1, q_o loads only at rising edges 8, 16, and so on, each time with the last four bits. At edge 4 it still shows its reset value.
- R6: With no slip, after rising edge k following reset release, clk_word_o is 1 exactly when (k mod 4) >= 2, and clk_pair_o is 1 exactly when (k mod 8) >= 4.
- R7: Suppose sync_i is first sampled high at edge k and stays high for at least two clocks. Then the divider does not advance at edge k+2. Every later load and divided-clock edge comes one clock later, so a bit that would have landed on q_o[n] lands on q_o[n-1].
- R8: sync_i held high gives one slip only. Another slip needs sync_i to return low for at least two clocks and then rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sin_a_i | input | 1 | Serial data input A |
| sin_b_i | input | 1 | Serial data input B (loopback) |
| sel_i | input | 1 | Input select: 0 = A, 1 = B |
| mode_i | input | 1 | Load rate: 0 = every 4 clocks, 1 = every 8 clocks |
| sync_i | input | 1 | Asynchronous slip request, one slip per rising pulse |
| q_o | output | 4 | Parallel word, q_o[0] holds the earliest bit |
| clk_word_o | output | 1 | Divide-by-4 clock |
| clk_pair_o | output | 1 | Divide-by-8 clock |
| sout_o | output | 1 | Registered echo of the selected serial input |

## Verification
The bench uses the default W = 4 and SYNC_STAGES = 2. With these values a full double-word cycle lasts eight clocks, so each table vector covers both load rates, both input selects and every divider phase in a few clocks. The two-stage synchronizer fixes the slip latency at two edges after first sampling. This allows an exact check of the stretched word clock, of where the boundary sits after a slip, of a long-held request giving a single slip, and of a second pulse giving a second slip.

// File: rtl/sp_deser_pkg.sv
package sp_deser_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;
  typedef enum logic {RATE_WORD = 1'b0, RATE_PAIR = 1'b1} rate_e;
endpackage

// File: rtl/sp_sync_rise.sv
module sp_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  // one pulse per low-to-high transition of the synchronized level
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/sp_div_chain.sv
module sp_div_chain
  import sp_deser_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hold_i,
  input  rate_e rate_i,
  output logic  load_o,
  output logic  div_lo_o,
  output logic  div_hi_o
);
  logic [CW-1:0] cnt_q;
  logic          term_lo, term_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!hold_i) cnt_q <= cnt_q + 1'b1;
  end

  assign term_lo  = &cnt_q[CW-2:0];
  assign term_hi  = &cnt_q;
  assign load_o   = ~hold_i & ((rate_i == RATE_PAIR) ? term_hi : term_lo);
  assign div_lo_o = cnt_q[CW-2];
  assign div_hi_o = cnt_q[CW-1];
endmodule

// File: rtl/sp_shift_word.sv
module sp_shift_word #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         load_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q, sh_d;

  // newest bit enters at the top; oldest drifts to bit 0
  assign sh_d = {bit_i, sh_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_o <= '0;
    end else begin
      sh_q <= sh_d;
      if (load_i) word_o <= sh_d;
    end
  end
endmodule

// File: rtl/sp_deser.sv
module sp_deser
  import sp_deser_pkg::*;
#(
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sin_a_i,
  input  logic         sin_b_i,
  input  logic         sel_i,
  input  logic         mode_i,
  input  logic         sync_i,
  output logic [W-1:0] q_o,
  output logic         clk_word_o,
  output logic         clk_pair_o,
  output logic         sout_o
);
  localparam int CW = $clog2(2 * W);

  logic ser_bit, slip, load;

  assign ser_bit = (src_e'(sel_i) == SRC_B) ? sin_b_i : sin_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sout_o <= 1'b0;
    else         sout_o <= ser_bit;
  end

  sp_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sync_i),
    .rise_o (slip)
  );

  sp_div_chain #(.CW(CW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (slip),
    .rate_i  (rate_e'(mode_i)),
    .load_o  (load),
    .div_lo_o(clk_word_o),
    .div_hi_o(clk_pair_o)
  );

  sp_shift_word #(.W(W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (ser_bit),
    .load_i(load),
    .word_o(q_o)
  );
endmodule

// File: rtl/sp_deser_chk.sv
module sp_deser_chk #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sin_a_i,
  input logic         sin_b_i,
  input logic         sel_i,
  input logic         mode_i,
  input logic [W-1:0] q_o,
  input logic         clk_word_o,
  input logic         clk_pair_o,
  input logic         sout_o,
  input logic         slip_i
);
  AST_SOUT_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sout_o == ($past(sel_i) ? $past(sin_b_i) : $past(sin_a_i))); // R2

  AST_LOAD_ON_WORD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> $fell(clk_word_o)); // R4

  AST_LOAD_ON_PAIR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(q_o) && $past(mode_i)) |-> $fell(clk_pair_o)); // R5

  AST_PAIR_FOLLOWS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_pair_o) |-> $fell(clk_word_o)); // R6

  AST_SLIP_FREEZES_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |=> ($stable(clk_word_o) && $stable(clk_pair_o))); // R7

  AST_SLIP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |=> !slip_i); // R8
endmodule

bind sp_deser sp_deser_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sin_a_i   (sin_a_i),
  .sin_b_i   (sin_b_i),
  .sel_i     (sel_i),
  .mode_i    (mode_i),
  .q_o       (q_o),
  .clk_word_o(clk_word_o),
  .clk_pair_o(clk_pair_o),
  .sout_o    (sout_o),
  .slip_i    (slip)
);

// File: tb/sim_sp_deser.sv
module sim_sp_deser;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sin_a_i = 1'b0, sin_b_i = 1'b0, sel_i = 1'b0, mode_i = 1'b0, sync_i = 1'b0;
  logic [3:0] q_o;
  logic       clk_word_o, clk_pair_o, sout_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  sp_deser u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sin_a_i(sin_a_i), .sin_b_i(sin_b_i),
    .sel_i(sel_i), .mode_i(mode_i), .sync_i(sync_i), .q_o(q_o),
    .clk_word_o(clk_word_o), .clk_pair_o(clk_pair_o), .sout_o(sout_o)
  );

  // {sel, mode, a_bits, b_bits, q after 4 bits, q after 8 bits}; bit i sent at edge i+1
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C, 4'h5, 4'hA},
    {1'b1, 1'b0, 8'hA5, 8'h3C, 4'hC, 4'h3},
    {1'b0, 1'b1, 8'h96, 8'h0F, 4'h0, 4'h9},
    {1'b1, 1'b1, 8'h96, 8'hE1, 4'h0, 4'hE},
    {1'b0, 1'b0, 8'h12, 8'hFF, 4'h2, 4'h1},
    {1'b1, 1'b1, 8'h00, 8'h7B, 4'h0, 4'h7}
  };
  localparam logic [31:0] PAT = 32'hB4E1_6D29;

  function automatic logic [3:0] word_at(int s);
    return {PAT[s+3], PAT[s+2], PAT[s+1], PAT[s]};
  endfunction

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic s);
    sin_a_i = a; sin_b_i = b; sync_i = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input logic sel, input logic mode);
    @(negedge clk);
    rst_ni = 1'b0; sel_i = sel; mode_i = mode; sync_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    // R1: reset state with inputs driven high
    sin_a_i = 1'b1; sin_b_i = 1'b1; sync_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(q_o, 4'h0, "R1");
    chk(4'(clk_word_o), 4'h0, "R1");
    chk(4'(clk_pair_o), 4'h0, "R1");
    chk(4'(sout_o), 4'h0, "R1");

    for (int v = 0; v < 6; v++) begin
      logic       sel, mode;
      logic [7:0] a, b;
      logic [3:0] mid, fin;
      {sel, mode, a, b, mid, fin} = VEC[v];
      restart(sel, mode);
      for (int k = 1; k <= 8; k++) begin
        step(a[k-1], b[k-1], 1'b0);
        chk(4'(sout_o), 4'(sel ? b[k-1] : a[k-1]), "R2");
        chk(4'(clk_word_o), 4'((k % 4) >= 2), "R6");
        chk(4'(clk_pair_o), 4'((k % 8) >= 4), "R6");
        if (k == 4) chk(q_o, mid, mode ? "R5" : "R3");
        if (k == 6) chk(q_o, mid, mode ? "R5" : "R4");
        if (k == 8) chk(q_o, fin, mode ? "R5" : "R4");
      end
    end

    // R1: asynchronous clear between edges
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #1;
    chk(q_o, 4'h0, "R1");
    chk(4'(clk_word_o | clk_pair_o | sout_o), 4'h0, "R1");

    // R7 / R8: slip from a long pulse, then a second pulse
    restart(1'b0, 1'b0);
    for (int k = 1; k <= 27; k++) begin
      logic s;
      s = ((k >= 5) && (k <= 16)) || ((k >= 21) && (k <= 24));
      step(PAT[k-1], 1'b0, s);
      case (k)
        4:  chk(q_o, word_at(0), "R4");
        8: begin
          chk(q_o, word_at(0), "R7");
          chk(4'(clk_word_o), 4'h1, "R7");
        end
        9:  chk(q_o, word_at(5), "R7");
        13: chk(q_o, word_at(9), "R8");
        17: chk(q_o, word_at(13), "R8");
        25: chk(q_o, word_at(17), "R8");
        26: chk(q_o, word_at(22), "R8");
        default: ;
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule